// File: doc/BRIEF.md
# Split I/D Request Dispatcher

This block sits at the front of a cache controller that keeps an instruction L1 and a data L1 side by side, under the rule that one line address may be held by at most one of the two arrays. Each cycle it selects one of four input queues by fixed priority. For core and prefetch requests it turns the request into a single event for the downstream coherence state machine. That event is a demand or prefetch event on the requested line, or a replacement event on a line that has to leave first.

The tag arrays are not part of the block. It drives a lookup address and receives, for that address, a presence flag from each cache, a free-way flag for each target set, and the victim line each cache would give up. The block is combinational from queue heads to the event output. Its only state is a record of one parked line address. A core request whose line is parked cannot win arbitration until a wake-up for that line arrives.

A queue head is dequeued only when the downstream state machine accepts the event, and only when the event actually consumes the request. A replacement leaves the request at the head so that it is retried once the line has moved.

Top module: `split_dispatch`

## Requirements
- R1: Queue priority is fixed: prefetch (highest), then response, then forwarded request, then core (lowest). The event reflects the highest-priority valid and eligible queue. Response events use code 8 and forwarded events use code 9; both carry the queue's address with the cache-select bit 0.
- R2: A request kind is encoded as 0 load, 1 ifetch, 2 store, 3 atomic. An ifetch uses the I-cache as its primary cache and all other kinds use the D-cache. On a primary hit the demand event is raised on the request address, with the cache-select bit equal to 1 for the D-cache and 0 for the I-cache. Demand codes are 1 load, 2 ifetch, 3 store.
- R3: A core request that misses its primary cache but is present in the other cache raises replacement code 4 on the request address, with the cache-select bit naming the other cache. The queue head is not dequeued.
- R4: A request present in neither cache whose primary target set has a free way raises its demand (or prefetch) event on the request address, with the primary cache selected.
- R5: A request present in neither cache whose primary target set is full raises replacement code 4 on the primary cache's victim address, with the primary cache selected. The queue head is not dequeued.
- R6: An atomic raises the same event code as a store (3 for core, 7 for prefetch).
- R7: Prefetch codes are 5 load, 6 ifetch, 7 store. When a prefetch finds its line in either cache, the prefetch event is raised with the drop flag set and the select bit naming the cache that holds the line. The request is dequeued on acceptance. Otherwise the drop flag is 0.
- R8: At most one queue is dequeued per cycle. A dequeue happens only in a cycle in which the event is valid and the ready input is high.
- R9: If the lookup reports the line present in both caches, the error output is high, no event is valid and no queue is dequeued.
- R10: When an accepted core event has the park input high, the core head is not dequeued and its line address is parked. A core head with that address then stays ineligible until a wake-up with the same address is seen. Wake-ups with other addresses have no effect, and a core head with a different address is still eligible.
- R11: After reset no address is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_valid | input | 1 | Prefetch queue head valid |
| pf_kind | input | 2 | Prefetch request kind |
| pf_addr | input | AW | Prefetch line address |
| pf_pop | output | 1 | Dequeue prefetch head |
| rsp_valid | input | 1 | Response queue head valid |
| rsp_addr | input | AW | Response line address |
| rsp_pop | output | 1 | Dequeue response head |
| fwd_valid | input | 1 | Forwarded-request queue head valid |
| fwd_addr | input | AW | Forwarded-request line address |
| fwd_pop | output | 1 | Dequeue forwarded-request head |
| core_valid | input | 1 | Core queue head valid |
| core_kind | input | 2 | Core request kind |
| core_addr | input | AW | Core line address |
| core_pop | output | 1 | Dequeue core head |
| look_addr | output | AW | Address presented to both tag arrays |
| ic_present | input | 1 | Lookup line held in I-cache |
| dc_present | input | 1 | Lookup line held in D-cache |
| ic_way_free | input | 1 | I-cache target set has a free way |
| dc_way_free | input | 1 | D-cache target set has a free way |
| ic_victim | input | AW | I-cache victim line for the target set |
| dc_victim | input | AW | D-cache victim line for the target set |
| ev_valid | output | 1 | Event valid |
| ev_code | output | 4 | Event code |
| ev_addr | output | AW | Event line address |
| ev_dsel | output | 1 | Event targets the D-cache (1) or the I-cache (0) |
| ev_drop | output | 1 | Prefetch found its line already cached |
| ev_ready | input | 1 | Downstream accepts the event |
| ev_park | input | 1 | Downstream stalls the accepted core request |
| wake_valid | input | 1 | Wake-up strobe |
| wake_addr | input | AW | Line address being woken |
| both_err | output | 1 | Line reported in both caches |

## Verification
The classification is swept over every combination of prefetch or core source, all four request kinds, all four presence pairs and all four free-way pairs. This separates primary hits, wrong-cache evictions, fills and victim replacements for each primary cache, and it covers the both-present error. All sixteen patterns of queue validity are then applied with ready both low and high. This shows the priority order and that nothing is dequeued unless the event is accepted. A parking sequence shows that a stalled core line stays blocked against unrelated wake-ups, that a different line still passes, and that the matching wake-up releases it.

// File: rtl/disp_pkg.sv
package disp_pkg;
   typedef enum logic [1:0] {
      K_LOAD   = 2'd0,
      K_IFETCH = 2'd1,
      K_STORE  = 2'd2,
      K_ATOMIC = 2'd3
   } req_kind_e;

   typedef enum logic [3:0] {
      EV_NONE      = 4'd0,
      EV_LOAD      = 4'd1,
      EV_IFETCH    = 4'd2,
      EV_STORE     = 4'd3,
      EV_REPL      = 4'd4,
      EV_PF_LOAD   = 4'd5,
      EV_PF_IFETCH = 4'd6,
      EV_PF_STORE  = 4'd7,
      EV_RESP      = 4'd8,
      EV_FWD       = 4'd9
   } ev_code_e;

   localparam int Q_PF   = 0;
   localparam int Q_RSP  = 1;
   localparam int Q_FWD  = 2;
   localparam int Q_CORE = 3;
   localparam int NUM_Q  = 4;
endpackage

// File: rtl/disp_arbiter.sv
module disp_arbiter #(
   parameter int NQ = 4
) (
   input  logic [NQ-1:0] req,
   output logic [NQ-1:0] gnt,
   output logic          any
);
   if (NQ < 2) begin : g_bad_nq
      $error("disp_arbiter: NQ must be at least 2");
   end

   // index 0 is the highest priority
   for (genvar i = 0; i < NQ; i++) begin : g_gnt
      if (i == 0) begin : g_top
         assign gnt[i] = req[i];
      end else begin : g_rest
         assign gnt[i] = req[i] & ~(|req[i-1:0]);
      end
   end

   assign any = |req;
endmodule

// File: rtl/disp_classify.sv
module disp_classify
   import disp_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          is_pf,
   input  req_kind_e     kind,
   input  logic [AW-1:0] req_addr,
   input  logic          ic_present,
   input  logic          dc_present,
   input  logic          ic_free,
   input  logic          dc_free,
   input  logic [AW-1:0] ic_victim,
   input  logic [AW-1:0] dc_victim,
   output ev_code_e      code,
   output logic [AW-1:0] out_addr,
   output logic          dsel,
   output logic          drop,
   output logic          repl,
   output logic          conflict
);
   logic          prim_d;
   logic          prim_hit;
   logic          oth_hit;
   logic          prim_free;
   logic [AW-1:0] prim_vic;
   ev_code_e      base;

   // primary cache: instruction fetches go to the I side, everything else to D
   always_comb begin
      prim_d    = (kind != K_IFETCH);
      prim_hit  = prim_d ? dc_present : ic_present;
      oth_hit   = prim_d ? ic_present : dc_present;
      prim_free = prim_d ? dc_free    : ic_free;
      prim_vic  = prim_d ? dc_victim  : ic_victim;
   end

   // stores and atomics share one event
   always_comb begin
      unique case (kind)
         K_LOAD:   base = is_pf ? EV_PF_LOAD   : EV_LOAD;
         K_IFETCH: base = is_pf ? EV_PF_IFETCH : EV_IFETCH;
         default:  base = is_pf ? EV_PF_STORE  : EV_STORE;
      endcase
   end

   always_comb begin
      code     = base;
      out_addr = req_addr;
      dsel     = prim_d;
      drop     = 1'b0;
      repl     = 1'b0;
      if (prim_hit) begin
         drop = is_pf;
      end else if (oth_hit) begin
         dsel = ~prim_d;
         if (is_pf) begin
            drop = 1'b1;
         end else begin
            code = EV_REPL;
            repl = 1'b1;
         end
      end else if (!prim_free) begin
         code     = EV_REPL;
         out_addr = prim_vic;
         repl     = 1'b1;
      end
   end

   assign conflict = ic_present & dc_present;
endmodule

// File: rtl/disp_park.sv
module disp_park #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set,
   input  logic [AW-1:0] set_addr,
   input  logic          wake_valid,
   input  logic [AW-1:0] wake_addr,
   input  logic [AW-1:0] probe_addr,
   output logic          blocked
);
   logic          park_vld;
   logic [AW-1:0] park_addr;
   logic          wake_hit;

   assign wake_hit = wake_valid & park_vld & (wake_addr == park_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         park_vld  <= 1'b0;
         park_addr <= '0;
      end else if (set) begin
         park_vld  <= 1'b1;
         park_addr <= set_addr;
      end else if (wake_hit) begin
         park_vld  <= 1'b0;
      end
   end

   assign blocked = park_vld & (probe_addr == park_addr);

   // R10
   wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_hit && !set) |=> !park_vld);

   // R10
   park_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (park_vld && !wake_hit && !set) |=> (park_vld && $stable(park_addr)));

   // R10
   park_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> (park_vld && park_addr == $past(set_addr)));
endmodule

// File: rtl/split_dispatch.sv
module split_dispatch
   import disp_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pf_valid,
   input  logic [1:0]    pf_kind,
   input  logic [AW-1:0] pf_addr,
   output logic          pf_pop,
   input  logic          rsp_valid,
   input  logic [AW-1:0] rsp_addr,
   output logic          rsp_pop,
   input  logic          fwd_valid,
   input  logic [AW-1:0] fwd_addr,
   output logic          fwd_pop,
   input  logic          core_valid,
   input  logic [1:0]    core_kind,
   input  logic [AW-1:0] core_addr,
   output logic          core_pop,
   output logic [AW-1:0] look_addr,
   input  logic          ic_present,
   input  logic          dc_present,
   input  logic          ic_way_free,
   input  logic          dc_way_free,
   input  logic [AW-1:0] ic_victim,
   input  logic [AW-1:0] dc_victim,
   output logic          ev_valid,
   output logic [3:0]    ev_code,
   output logic [AW-1:0] ev_addr,
   output logic          ev_dsel,
   output logic          ev_drop,
   input  logic          ev_ready,
   input  logic          ev_park,
   input  logic          wake_valid,
   input  logic [AW-1:0] wake_addr,
   output logic          both_err
);
   localparam int NQ = NUM_Q;

   if (AW < 2) begin : g_bad_aw
      $error("split_dispatch: AW must be at least 2");
   end

   logic [NQ-1:0] req;
   logic [NQ-1:0] gnt;
   logic [NQ-1:0] pops;
   logic          any;
   logic          core_blocked;
   logic [AW-1:0] q_addr [NQ];

   // ---------------- arbitration ----------------
   assign req[Q_PF]   = pf_valid;
   assign req[Q_RSP]  = rsp_valid;
   assign req[Q_FWD]  = fwd_valid;
   assign req[Q_CORE] = core_valid & ~core_blocked;

   disp_arbiter #(.NQ(NQ)) arb_i (
      .req (req),
      .gnt (gnt),
      .any (any)
   );

   assign q_addr[Q_PF]   = pf_addr;
   assign q_addr[Q_RSP]  = rsp_addr;
   assign q_addr[Q_FWD]  = fwd_addr;
   assign q_addr[Q_CORE] = core_addr;

   always_comb begin
      look_addr = '0;
      for (int i = 0; i < NQ; i++) begin
         if (gnt[i]) look_addr = q_addr[i];
      end
   end

   // ---------------- classification ----------------
   logic          use_cls;
   logic          is_pf;
   req_kind_e     cls_kind;
   ev_code_e      cls_code;
   logic [AW-1:0] cls_addr;
   logic          cls_dsel;
   logic          cls_drop;
   logic          cls_repl;
   logic          cls_conflict;

   assign is_pf    = gnt[Q_PF];
   assign use_cls  = gnt[Q_PF] | gnt[Q_CORE];
   assign cls_kind = req_kind_e'(is_pf ? pf_kind : core_kind);

   disp_classify #(.AW(AW)) cls_i (
      .is_pf      (is_pf),
      .kind       (cls_kind),
      .req_addr   (look_addr),
      .ic_present (ic_present),
      .dc_present (dc_present),
      .ic_free    (ic_way_free),
      .dc_free    (dc_way_free),
      .ic_victim  (ic_victim),
      .dc_victim  (dc_victim),
      .code       (cls_code),
      .out_addr   (cls_addr),
      .dsel       (cls_dsel),
      .drop       (cls_drop),
      .repl       (cls_repl),
      .conflict   (cls_conflict)
   );

   // ---------------- event output ----------------
   ev_code_e code_mux;

   always_comb begin
      if (use_cls)           code_mux = cls_code;
      else if (gnt[Q_RSP])   code_mux = EV_RESP;
      else if (gnt[Q_FWD])   code_mux = EV_FWD;
      else                   code_mux = EV_NONE;
   end

   assign both_err = use_cls & cls_conflict;
   assign ev_valid = any & ~both_err;
   assign ev_code  = code_mux;
   assign ev_addr  = use_cls ? cls_addr : look_addr;
   assign ev_dsel  = use_cls & cls_dsel;
   assign ev_drop  = use_cls & cls_drop;

   // ---------------- dequeue and parking ----------------
   logic accept;
   logic park_set;
   logic consume;

   assign accept   = ev_valid & ev_ready;
   assign park_set = accept & gnt[Q_CORE] & ev_park & ~cls_repl;
   assign consume  = accept & ~(use_cls & cls_repl) & ~park_set;
   assign pops     = gnt & {NQ{consume}};

   assign pf_pop   = pops[Q_PF];
   assign rsp_pop  = pops[Q_RSP];
   assign fwd_pop  = pops[Q_FWD];
   assign core_pop = pops[Q_CORE];

   disp_park #(.AW(AW)) park_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .set        (park_set),
      .set_addr   (core_addr),
      .wake_valid (wake_valid),
      .wake_addr  (wake_addr),
      .probe_addr (core_addr),
      .blocked    (core_blocked)
   );

   // ---------------- checks ----------------
   // R8
   pop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pf_pop, rsp_pop, fwd_pop, core_pop}));

   // R8
   pop_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_pop || rsp_pop || fwd_pop || core_pop) |-> (ev_valid && ev_ready));

   // R1
   core_pop_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_pop |-> (!pf_valid && !rsp_valid && !fwd_valid));

   // R9
   conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ic_present && dc_present && (pf_valid || (core_valid && !rsp_valid && !fwd_valid)))
      |-> (!ev_valid || !pf_valid && (rsp_valid || fwd_valid) || !pf_valid && !core_pop));

   // R3
   repl_keeps_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_code == 4'd4) |-> !(pf_pop || core_pop));

   // R10
   parked_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_ready && ev_park && core_pop) |-> pf_valid == 1'b0 && 1'b0);
endmodule

// File: tb/split_dispatch_tb.sv
`timescale 1ns/1ps
module split_dispatch_tb_top;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pf_valid = 0, rsp_valid = 0, fwd_valid = 0, core_valid = 0;
   logic [1:0]    pf_kind = 0, core_kind = 0;
   logic [AW-1:0] pf_addr = 0, rsp_addr = 0, fwd_addr = 0, core_addr = 0;
   logic          pf_pop, rsp_pop, fwd_pop, core_pop;
   logic [AW-1:0] look_addr;
   logic          ic_present = 0, dc_present = 0, ic_way_free = 1, dc_way_free = 1;
   logic [AW-1:0] ic_victim = 8'hA5, dc_victim = 8'h5A;
   logic          ev_valid, ev_dsel, ev_drop, both_err;
   logic [3:0]    ev_code;
   logic [AW-1:0] ev_addr;
   logic          ev_ready = 0, ev_park = 0, wake_valid = 0;
   logic [AW-1:0] wake_addr = 0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   split_dispatch #(.AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .pf_valid(pf_valid), .pf_kind(pf_kind), .pf_addr(pf_addr), .pf_pop(pf_pop),
      .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_pop(rsp_pop),
      .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_pop(fwd_pop),
      .core_valid(core_valid), .core_kind(core_kind), .core_addr(core_addr), .core_pop(core_pop),
      .look_addr(look_addr),
      .ic_present(ic_present), .dc_present(dc_present),
      .ic_way_free(ic_way_free), .dc_way_free(dc_way_free),
      .ic_victim(ic_victim), .dc_victim(dc_victim),
      .ev_valid(ev_valid), .ev_code(ev_code), .ev_addr(ev_addr),
      .ev_dsel(ev_dsel), .ev_drop(ev_drop), .ev_ready(ev_ready), .ev_park(ev_park),
      .wake_valid(wake_valid), .wake_addr(wake_addr), .both_err(both_err)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [3:0] pops_now();
      return {core_pop, fwd_pop, rsp_pop, pf_pop};
   endfunction

   initial begin : watchdog
      #400000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #1;
      // R11: nothing parked after reset, so a core request passes; idle gives nothing
      check("R11 idle", {ev_valid, pops_now()}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      core_valid = 1; core_addr = 8'h44; core_kind = 0;
      #1;
      check("R11 core eligible after reset", {ev_valid, ev_code}, {1'b1, 4'd1});
      core_valid = 0;

      // classification sweep
      ev_ready = 1;
      for (int v = 0; v < 128; v++) begin
         logic pf, ic, dc, icf, dcf, pd, ph, oh, pfree, rep, drp, ds, err;
         logic [1:0] k;
         logic [3:0] base, ecode;
         logic [AW-1:0] a, ea;
         string tag;
         pf = v[6]; k = v[5:4]; ic = v[3]; dc = v[2]; icf = v[1]; dcf = v[0];
         a = 8'h10 + v[7:0];
         @(negedge clk);
         pf_valid = pf; core_valid = !pf;
         pf_kind = k; core_kind = k; pf_addr = a; core_addr = a;
         ic_present = ic; dc_present = dc; ic_way_free = icf; dc_way_free = dcf;
         #1;
         pd = (k != 2'd1);
         ph = pd ? dc : ic; oh = pd ? ic : dc; pfree = pd ? dcf : icf;
         base = (k == 2'd0) ? 4'd1 : (k == 2'd1) ? 4'd2 : 4'd3;
         if (pf) base = base + 4'd4;
         ecode = base; ea = a; ds = pd; drp = 0; rep = 0; err = ic & dc;
         if (ph) begin drp = pf; tag = pf ? "R7 present" : "R2 hit"; end
         else if (oh) begin
            ds = !pd;
            if (pf) begin drp = 1; tag = "R7 other"; end
            else begin ecode = 4'd4; rep = 1; tag = "R3 wrong cache"; end
         end else if (pfree) tag = (k == 2'd3) ? "R6 atomic fill" : "R4 fill";
         else begin ecode = 4'd4; ea = pd ? 8'h5A : 8'hA5; rep = 1; tag = "R5 victim"; end
         if (err) begin
            check("R9 both present", {both_err, ev_valid, pops_now()}, {1'b1, 1'b0, 4'd0});
         end else begin
            check(tag, {ev_valid, ev_code, ev_addr, ev_dsel, ev_drop, both_err, pops_now()},
                  {1'b1, ecode, ea, ds, drp, 1'b0, rep ? 4'd0 : (pf ? 4'b0001 : 4'b1000)});
         end
      end

      // priority sweep
      @(negedge clk);
      ic_present = 0; dc_present = 0; ic_way_free = 1; dc_way_free = 1;
      pf_kind = 0; core_kind = 0;
      pf_addr = 8'h11; rsp_addr = 8'h22; fwd_addr = 8'h33; core_addr = 8'h44;
      for (int m = 0; m < 32; m++) begin
         logic [3:0] msk, ep, ec;
         logic [AW-1:0] ea;
         logic ds;
         int w;
         msk = m[3:0];
         @(negedge clk);
         {core_valid, fwd_valid, rsp_valid, pf_valid} = msk;
         ev_ready = m[4];
         #1;
         w = msk[0] ? 0 : msk[1] ? 1 : msk[2] ? 2 : msk[3] ? 3 : 4;
         case (w)
            0: begin ec = 4'd5; ea = 8'h11; ds = 1; end
            1: begin ec = 4'd8; ea = 8'h22; ds = 0; end
            2: begin ec = 4'd9; ea = 8'h33; ds = 0; end
            3: begin ec = 4'd1; ea = 8'h44; ds = 1; end
            default: begin ec = 4'd0; ea = 8'h00; ds = 0; end
         endcase
         ep = (w < 4 && ev_ready) ? (4'd1 << w) : 4'd0;
         if (w == 4)
            check("R8 idle no pop", {ev_valid, pops_now()}, 0);
         else
            check("R1 priority / R8 pop gating", {ev_valid, ev_code, ev_addr, ev_dsel, pops_now()},
                  {1'b1, ec, ea, ds, ep});
      end

      // parking
      @(negedge clk);
      {core_valid, fwd_valid, rsp_valid, pf_valid} = 4'b1000;
      core_addr = 8'h44; ev_ready = 1; ev_park = 1;
      #1;
      check("R10 parked request not popped", {ev_valid, pops_now()}, {1'b1, 4'd0});
      @(posedge clk); #1;
      ev_park = 0;
      check("R10 parked line blocked", {ev_valid, pops_now()}, 0);
      @(negedge clk);
      wake_valid = 1; wake_addr = 8'h45;
      @(posedge clk); #1;
      wake_valid = 0;
      check("R10 unrelated wake ignored", {ev_valid, pops_now()}, 0);
      @(negedge clk);
      core_addr = 8'h46;
      #1;
      check("R10 other line eligible", {ev_valid, ev_addr, pops_now()}, {1'b1, 8'h46, 4'b1000});
      @(negedge clk);
      ev_ready = 0; core_addr = 8'h44;
      wake_valid = 1; wake_addr = 8'h44;
      @(posedge clk); #1;
      wake_valid = 0;
      check("R10 matching wake releases", {ev_valid, ev_addr}, {1'b1, 8'h44});

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule